// File: doc/BRIEF.md
# Dual-Array TLB Write and Flush Controller

This block sits between the translation-management register interface and two physically separate TLB arrays: a small host array and a larger guest array. Software sees one flat entry-number space: the low part of that space selects host entries and the upper part selects guest entries. The block holds the software-loaded entry pointer. It also keeps a hardware-driven random pick, built on a free-running linear feedback shift register, and it decodes write commands into a per-array write strobe, entry number and entry payload.

An indexed write takes its target from the stored pointer. A random write takes its target from the page-size field of the entry being written. If that field equals the guest array's fixed page mask, a random guest entry is written. Otherwise a random host entry is written. Two flush bits on a diagnostic write clear all valid bits of one array, or of both, in a single cycle. The block tracks one valid bit per entry and drives these bits out to the arrays.

If the pointer holds a value beyond the last guest entry, an indexed write is dropped and a sticky error flag is raised. Lookup and exception generation belong to other blocks.

Top module: `tlb_write_ctrl`

## Requirements
- R1: After reset the pointer reads 0, the random readback reads 0, the error flag is 0, both write strobes and both flush pulses are 0, and every valid bit of both arrays is 0.
- R2: When `index_wr` is high, `index_rd` shows `index_wdata` from the next clock edge on.
- R3: An indexed write is decoded from the pointer value held before the edge, so a pointer load in the same cycle does not affect it. A value `v` below HOST_N (64) writes host entry `v`. A value from HOST_N to HOST_N+GUEST_N-1 (1087) writes guest entry `v`-HOST_N. The strobe, the entry number and the registered mask and body all appear one cycle after the command.
- R4: An indexed write with a pointer value above HOST_N+GUEST_N-1 raises no strobe and changes no valid bit. It sets `index_err`, which stays at 1 until reset.
- R5: A random write whose `entry_mask` equals GUEST_PAGE_MASK (default 16'h0000) writes a guest entry. `random_rd` then equals HOST_N plus that entry number, which lies in the range 64 to 1087.
- R6: A random write with any other mask writes a host entry. `random_rd` then equals that entry number, which lies in the range 0 to 63.
- R7: The random source advances on every clock, so random writes issued in different cycles do not all land on the same entry.
- R8: When an indexed write and a random write are requested in the same cycle, only the indexed write is performed.
- R9: A diagnostic write with bit 0 set gives a one-cycle `host_flush` pulse and clears every host valid bit. A diagnostic write with bit 1 set does the same for `guest_flush` and the guest valid bits. The array that is not flushed keeps its valid bits.
- R10: A write sets the valid bit of its target entry. A write in the same cycle as a flush of its array leaves that entry valid and every other entry of the array clear.
- R11: At most one of `host_we` and `guest_we` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| index_wr | input | 1 | Load the entry pointer |
| index_wdata | input | IDX_W | New pointer value |
| diag_wr | input | 1 | Diagnostic write |
| diag_wdata | input | 2 | Bit 0 flushes the host array, bit 1 flushes the guest array |
| write_indexed | input | 1 | Write the entry at the pointer |
| write_random | input | 1 | Write a hardware-chosen entry |
| entry_mask | input | MASK_W | Page-size field of the entry |
| entry_body | input | BODY_W | Remaining entry fields |
| index_rd | output | IDX_W | Current pointer |
| random_rd | output | IDX_W | Flat number of the last random write |
| index_err | output | 1 | Sticky flag for an out-of-range indexed write |
| host_we | output | 1 | Host array write strobe |
| host_addr | output | HOST_AW | Host entry number |
| guest_we | output | 1 | Guest array write strobe |
| guest_addr | output | GUEST_AW | Guest entry number |
| wr_mask | output | MASK_W | Registered page-size field |
| wr_body | output | BODY_W | Registered entry fields |
| host_flush | output | 1 | Host flush pulse |
| guest_flush | output | 1 | Guest flush pulse |
| host_valid | output | HOST_N | Host valid bits |
| guest_valid | output | GUEST_N | Guest valid bits |

## Verification
The assertions take the command inputs as single-cycle requests sampled at each edge. They also rely on the free-running register never holding all zeros, which follows from its nonzero seed. The sticky-error and flush-pulse checks assume the command and diagnostic inputs are known (not X) whenever reset is released. The bench drives every input to a defined value at a falling edge and holds it through the next rising edge. It issues each command for exactly one cycle and sends overlapping commands only in the scenarios that test command priority and flush-with-write.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;

    // Bit positions inside the diagnostic write word
    localparam int DIAG_HOST_BIT  = 0;
    localparam int DIAG_GUEST_BIT = 1;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_HOST  = 2'd1,
        TGT_GUEST = 2'd2
    } tgt_e;

endpackage

// File: rtl/tlbw_random.sv
module tlbw_random #(
    parameter int                HOST_N   = 64,
    parameter int                GUEST_N  = 1024,
    parameter int                LFSR_W   = 16,
    parameter logic [LFSR_W-1:0] TAPS     = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED     = 16'hACE1,
    parameter int                HOST_AW  = $clog2(HOST_N),
    parameter int                GUEST_AW = $clog2(GUEST_N)
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [HOST_AW-1:0]  host_pick_o,
    output logic [GUEST_AW-1:0] guest_pick_o
);

    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    // Galois step, taken every cycle
    always_comb begin
        lfsr_d = lfsr_q >> 1;
        if (lfsr_q[0]) begin
            lfsr_d = lfsr_d ^ TAPS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else begin
            lfsr_q <= lfsr_d;
        end
    end

    assign host_pick_o  = HOST_AW'(lfsr_q % LFSR_W'(HOST_N));
    assign guest_pick_o = GUEST_AW'(lfsr_q % LFSR_W'(GUEST_N));

    // R7
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    // R7
    lfsr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> !$stable(lfsr_q));

endmodule

// File: rtl/tlbw_decode.sv
module tlbw_decode
    import tlbw_pkg::*;
#(
    parameter int                HOST_N          = 64,
    parameter int                GUEST_N         = 1024,
    parameter int                MASK_W          = 16,
    parameter logic [MASK_W-1:0] GUEST_PAGE_MASK = '0,
    parameter int                IDX_W           = $clog2(HOST_N + GUEST_N),
    parameter int                HOST_AW         = $clog2(HOST_N),
    parameter int                GUEST_AW        = $clog2(GUEST_N)
) (
    input  logic [IDX_W-1:0]    index_i,
    input  logic                cmd_idx_i,
    input  logic                cmd_rnd_i,
    input  logic [MASK_W-1:0]   mask_i,
    input  logic [HOST_AW-1:0]  host_pick_i,
    input  logic [GUEST_AW-1:0] guest_pick_i,
    output tgt_e                tgt_o,
    output logic [HOST_AW-1:0]  host_addr_o,
    output logic [GUEST_AW-1:0] guest_addr_o,
    output logic                err_o,
    output logic                rnd_used_o,
    output logic [IDX_W-1:0]    rnd_flat_o
);

    localparam logic [IDX_W:0]   HOST_LIM  = (IDX_W+1)'(HOST_N);
    localparam logic [IDX_W:0]   TOTAL_LIM = (IDX_W+1)'(HOST_N + GUEST_N);
    localparam logic [IDX_W-1:0] GUEST_BASE = IDX_W'(HOST_N);

    logic [IDX_W:0]   index_ext;
    logic [IDX_W-1:0] guest_rel;

    assign index_ext = {1'b0, index_i};
    assign guest_rel = index_i - GUEST_BASE;

    always_comb begin
        tgt_o        = TGT_NONE;
        host_addr_o  = host_pick_i;
        guest_addr_o = guest_pick_i;
        err_o        = 1'b0;
        rnd_used_o   = 1'b0;
        rnd_flat_o   = '0;
        if (cmd_idx_i) begin
            // indexed command wins over a random one in the same cycle
            if (index_ext < HOST_LIM) begin
                tgt_o       = TGT_HOST;
                host_addr_o = index_i[HOST_AW-1:0];
            end else if (index_ext < TOTAL_LIM) begin
                tgt_o        = TGT_GUEST;
                guest_addr_o = guest_rel[GUEST_AW-1:0];
            end else begin
                err_o = 1'b1;
            end
        end else if (cmd_rnd_i) begin
            rnd_used_o = 1'b1;
            if (mask_i == GUEST_PAGE_MASK) begin
                tgt_o      = TGT_GUEST;
                rnd_flat_o = GUEST_BASE + IDX_W'(guest_pick_i);
            end else begin
                tgt_o      = TGT_HOST;
                rnd_flat_o = IDX_W'(host_pick_i);
            end
        end
    end

endmodule

// File: rtl/tlbw_valid.sv
module tlbw_valid #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    output logic [DEPTH-1:0] valid_o
);

    logic [DEPTH-1:0] valid_d, valid_q;

    // Flush first, then the write, so a same-cycle write survives
    always_comb begin
        valid_d = valid_q;
        if (flush_i) begin
            valid_d = '0;
        end
        if (we_i) begin
            valid_d[addr_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    assign valid_o = valid_q;

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i && !we_i |=> valid_o == '0);

    // R10
    write_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> valid_o[$past(addr_i)]);

    // R10
    flush_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i && we_i |=> $countones(valid_o) == 1);

endmodule

// File: rtl/tlb_write_ctrl.sv
module tlb_write_ctrl
    import tlbw_pkg::*;
#(
    parameter int                HOST_N          = 64,
    parameter int                GUEST_N         = 1024,
    parameter int                MASK_W          = 16,
    parameter int                BODY_W          = 48,
    parameter logic [MASK_W-1:0] GUEST_PAGE_MASK = '0,
    parameter int                LFSR_W          = 16,
    parameter int                IDX_W           = $clog2(HOST_N + GUEST_N),
    parameter int                HOST_AW         = $clog2(HOST_N),
    parameter int                GUEST_AW        = $clog2(GUEST_N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                index_wr,
    input  logic [IDX_W-1:0]    index_wdata,
    input  logic                diag_wr,
    input  logic [1:0]          diag_wdata,
    input  logic                write_indexed,
    input  logic                write_random,
    input  logic [MASK_W-1:0]   entry_mask,
    input  logic [BODY_W-1:0]   entry_body,
    output logic [IDX_W-1:0]    index_rd,
    output logic [IDX_W-1:0]    random_rd,
    output logic                index_err,
    output logic                host_we,
    output logic [HOST_AW-1:0]  host_addr,
    output logic                guest_we,
    output logic [GUEST_AW-1:0] guest_addr,
    output logic [MASK_W-1:0]   wr_mask,
    output logic [BODY_W-1:0]   wr_body,
    output logic                host_flush,
    output logic                guest_flush,
    output logic [HOST_N-1:0]   host_valid,
    output logic [GUEST_N-1:0]  guest_valid
);

    localparam logic [IDX_W:0] HOST_LIM = (IDX_W+1)'(HOST_N);

    typedef struct packed {
        logic [IDX_W-1:0]    index;
        logic [IDX_W-1:0]    rand_flat;
        logic                err;
        logic                host_we;
        logic                guest_we;
        logic [HOST_AW-1:0]  host_addr;
        logic [GUEST_AW-1:0] guest_addr;
        logic [MASK_W-1:0]   mask;
        logic [BODY_W-1:0]   body;
        logic                host_fl;
        logic                guest_fl;
    } regs_t;

    regs_t r_d, r_q;

    logic [HOST_AW-1:0]  host_pick;
    logic [GUEST_AW-1:0] guest_pick;
    tgt_e                dec_tgt;
    logic [HOST_AW-1:0]  dec_host_addr;
    logic [GUEST_AW-1:0] dec_guest_addr;
    logic                dec_err;
    logic                dec_rnd_used;
    logic [IDX_W-1:0]    dec_rnd_flat;
    logic                host_fl_req;
    logic                guest_fl_req;
    logic                host_wr_req;
    logic                guest_wr_req;

    tlbw_random #(
        .HOST_N   (HOST_N),
        .GUEST_N  (GUEST_N),
        .LFSR_W   (LFSR_W),
        .HOST_AW  (HOST_AW),
        .GUEST_AW (GUEST_AW)
    ) i_random (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_pick_o  (host_pick),
        .guest_pick_o (guest_pick)
    );

    tlbw_decode #(
        .HOST_N          (HOST_N),
        .GUEST_N         (GUEST_N),
        .MASK_W          (MASK_W),
        .GUEST_PAGE_MASK (GUEST_PAGE_MASK),
        .IDX_W           (IDX_W),
        .HOST_AW         (HOST_AW),
        .GUEST_AW        (GUEST_AW)
    ) i_decode (
        .index_i      (r_q.index),
        .cmd_idx_i    (write_indexed),
        .cmd_rnd_i    (write_random),
        .mask_i       (entry_mask),
        .host_pick_i  (host_pick),
        .guest_pick_i (guest_pick),
        .tgt_o        (dec_tgt),
        .host_addr_o  (dec_host_addr),
        .guest_addr_o (dec_guest_addr),
        .err_o        (dec_err),
        .rnd_used_o   (dec_rnd_used),
        .rnd_flat_o   (dec_rnd_flat)
    );

    assign host_fl_req  = diag_wr && diag_wdata[DIAG_HOST_BIT];
    assign guest_fl_req = diag_wr && diag_wdata[DIAG_GUEST_BIT];
    assign host_wr_req  = (dec_tgt == TGT_HOST);
    assign guest_wr_req = (dec_tgt == TGT_GUEST);

    always_comb begin
        r_d          = r_q;
        r_d.host_we  = host_wr_req;
        r_d.guest_we = guest_wr_req;
        r_d.host_fl  = host_fl_req;
        r_d.guest_fl = guest_fl_req;
        if (index_wr) begin
            r_d.index = index_wdata;
        end
        if (dec_err) begin
            r_d.err = 1'b1;
        end
        if (dec_rnd_used) begin
            r_d.rand_flat = dec_rnd_flat;
        end
        if (host_wr_req) begin
            r_d.host_addr = dec_host_addr;
        end
        if (guest_wr_req) begin
            r_d.guest_addr = dec_guest_addr;
        end
        if (host_wr_req || guest_wr_req) begin
            r_d.mask = entry_mask;
            r_d.body = entry_body;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    tlbw_valid #(
        .DEPTH (HOST_N),
        .AW    (HOST_AW)
    ) i_host_valid (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (host_fl_req),
        .we_i    (host_wr_req),
        .addr_i  (dec_host_addr),
        .valid_o (host_valid)
    );

    tlbw_valid #(
        .DEPTH (GUEST_N),
        .AW    (GUEST_AW)
    ) i_guest_valid (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (guest_fl_req),
        .we_i    (guest_wr_req),
        .addr_i  (dec_guest_addr),
        .valid_o (guest_valid)
    );

    assign index_rd    = r_q.index;
    assign random_rd   = r_q.rand_flat;
    assign index_err   = r_q.err;
    assign host_we     = r_q.host_we;
    assign host_addr   = r_q.host_addr;
    assign guest_we    = r_q.guest_we;
    assign guest_addr  = r_q.guest_addr;
    assign wr_mask     = r_q.mask;
    assign wr_body     = r_q.body;
    assign host_flush  = r_q.host_fl;
    assign guest_flush = r_q.guest_fl;

    // R11
    one_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_we, guest_we}));

    // R2
    index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        index_wr |=> index_rd == $past(index_wdata));

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        index_err |=> index_err);

    // R4
    err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        write_indexed && {1'b0, r_q.index} >= (IDX_W+1)'(HOST_N + GUEST_N) |=> !host_we && !guest_we);

    // R5
    rand_guest_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        guest_we && $past(write_random && !write_indexed) |-> {1'b0, random_rd} >= HOST_LIM);

    // R6
    rand_host_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && $past(write_random && !write_indexed) |-> {1'b0, random_rd} < HOST_LIM);

    // R9
    host_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_flush |-> $past(diag_wr && diag_wdata[DIAG_HOST_BIT]));

    // R9
    guest_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        guest_flush |-> $past(diag_wr && diag_wdata[DIAG_GUEST_BIT]));

endmodule

// File: tb/test_tlb_write_ctrl.sv
module test_tlb_write_ctrl;

    localparam int HOST_N   = 64;
    localparam int GUEST_N  = 1024;
    localparam int IDX_W    = 11;
    localparam int HOST_AW  = 6;
    localparam int GUEST_AW = 10;
    localparam int MASK_W   = 16;
    localparam int BODY_W   = 48;
    localparam logic [MASK_W-1:0] GMASK = 16'h0000;
    localparam logic [MASK_W-1:0] HMASK = 16'h0003;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                index_wr = 1'b0;
    logic [IDX_W-1:0]    index_wdata = '0;
    logic                diag_wr = 1'b0;
    logic [1:0]          diag_wdata = '0;
    logic                write_indexed = 1'b0;
    logic                write_random = 1'b0;
    logic [MASK_W-1:0]   entry_mask = '0;
    logic [BODY_W-1:0]   entry_body = '0;
    logic [IDX_W-1:0]    index_rd;
    logic [IDX_W-1:0]    random_rd;
    logic                index_err;
    logic                host_we;
    logic [HOST_AW-1:0]  host_addr;
    logic                guest_we;
    logic [GUEST_AW-1:0] guest_addr;
    logic [MASK_W-1:0]   wr_mask;
    logic [BODY_W-1:0]   wr_body;
    logic                host_flush;
    logic                guest_flush;
    logic [HOST_N-1:0]   host_valid;
    logic [GUEST_N-1:0]  guest_valid;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tlb_write_ctrl i_tlb_write_ctrl (
        .clk(clk), .rst_n(rst_n), .index_wr(index_wr), .index_wdata(index_wdata),
        .diag_wr(diag_wr), .diag_wdata(diag_wdata), .write_indexed(write_indexed),
        .write_random(write_random), .entry_mask(entry_mask), .entry_body(entry_body),
        .index_rd(index_rd), .random_rd(random_rd), .index_err(index_err),
        .host_we(host_we), .host_addr(host_addr), .guest_we(guest_we),
        .guest_addr(guest_addr), .wr_mask(wr_mask), .wr_body(wr_body),
        .host_flush(host_flush), .guest_flush(guest_flush),
        .host_valid(host_valid), .guest_valid(guest_valid)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic load_index(input int v);
        index_wr    = 1'b1;
        index_wdata = IDX_W'(v);
        step();
        index_wr    = 1'b0;
    endtask

    task automatic t_reset();
        chk(index_rd == 0, "R1 index", index_rd, 0);
        chk(random_rd == 0, "R1 random", random_rd, 0);
        chk(index_err == 0, "R1 err", index_err, 0);
        chk({host_we, guest_we, host_flush, guest_flush} == 0, "R1 strobes",
            {host_we, guest_we, host_flush, guest_flush}, 0);
        chk($countones(host_valid) + $countones(guest_valid) == 0, "R1 valid",
            $countones(host_valid) + $countones(guest_valid), 0);
    endtask

    task automatic t_index_load();
        load_index(5);
        chk(index_rd == 5, "R2 load", index_rd, 5);
        load_index(1087);
        chk(index_rd == 1087, "R2 load max", index_rd, 1087);
    endtask

    task automatic idx_write(input int v, input bit exp_host, input int exp_entry, input logic [BODY_W-1:0] body);
        load_index(v);
        write_indexed = 1'b1;
        entry_mask    = HMASK;
        entry_body    = body;
        step();
        write_indexed = 1'b0;
        if (exp_host) begin
            chk(host_we && !guest_we, "R3 host strobe", {host_we, guest_we}, 2);
            chk(host_addr == exp_entry, "R3 host entry", host_addr, exp_entry);
            chk(host_valid[exp_entry], "R10 host valid set", host_valid[exp_entry], 1);
        end else begin
            chk(guest_we && !host_we, "R3 guest strobe", {host_we, guest_we}, 1);
            chk(guest_addr == exp_entry, "R3 guest entry", guest_addr, exp_entry);
            chk(guest_valid[exp_entry], "R10 guest valid set", guest_valid[exp_entry], 1);
        end
        chk(wr_body == body && wr_mask == HMASK, "R3 payload", longint'(wr_body), longint'(body));
        step();
        chk(!host_we && !guest_we, "R11 strobe drops", {host_we, guest_we}, 0);
    endtask

    task automatic t_indexed();
        idx_write(10, 1'b1, 10, 48'h1234_5678_9ABC);
        idx_write(63, 1'b1, 63, 48'h0000_0000_0063);
        idx_write(64, 1'b0, 0, 48'hAAAA_0000_0064);
        idx_write(1087, 1'b0, 1023, 48'h5555_0000_1087);
    endtask

    task automatic t_load_and_write_same_cycle();
        load_index(3);
        index_wr      = 1'b1;
        index_wdata   = IDX_W'(70);
        write_indexed = 1'b1;
        step();
        index_wr      = 1'b0;
        chk(host_we && host_addr == 3, "R3 old pointer used", host_addr, 3);
        step();
        chk(guest_we && guest_addr == 6, "R3 new pointer next write", guest_addr, 6);
        write_indexed = 1'b0;
        step();
    endtask

    task automatic t_out_of_range();
        int hv, gv;
        hv = $countones(host_valid);
        gv = $countones(guest_valid);
        load_index(1088);
        write_indexed = 1'b1;
        step();
        write_indexed = 1'b0;
        chk(!host_we && !guest_we, "R4 no strobe", {host_we, guest_we}, 0);
        chk(index_err == 1, "R4 err set", index_err, 1);
        chk($countones(host_valid) == hv && $countones(guest_valid) == gv, "R4 valid unchanged",
            $countones(host_valid) + $countones(guest_valid), hv + gv);
        load_index(2047);
        write_indexed = 1'b1;
        step();
        write_indexed = 1'b0;
        chk(!host_we && !guest_we, "R4 no strobe top", {host_we, guest_we}, 0);
        load_index(2);
        write_indexed = 1'b1;
        step();
        write_indexed = 1'b0;
        chk(host_we && host_addr == 2, "R3 write after error", host_addr, 2);
        chk(index_err == 1, "R4 err sticky", index_err, 1);
        step();
    endtask

    task automatic t_random_guest();
        int first;
        int distinct;
        first = -1;
        distinct = 0;
        for (int k = 0; k < 8; k++) begin
            write_random = 1'b1;
            entry_mask   = GMASK;
            step();
            write_random = 1'b0;
            chk(guest_we && !host_we, "R5 guest strobe", {host_we, guest_we}, 1);
            chk(random_rd >= 64 && random_rd <= 1087, "R5 random range", random_rd, 64);
            chk(random_rd == 64 + guest_addr, "R5 random matches entry", random_rd, 64 + guest_addr);
            chk(guest_valid[guest_addr], "R10 random valid", guest_valid[guest_addr], 1);
            if (first < 0) first = guest_addr;
            else if (guest_addr != first) distinct++;
            for (int w = 0; w < k; w++) step();
        end
        chk(distinct > 0, "R7 random advances", distinct, 1);
    endtask

    task automatic t_random_host();
        for (int k = 0; k < 4; k++) begin
            write_random = 1'b1;
            entry_mask   = HMASK;
            step();
            write_random = 1'b0;
            chk(host_we && !guest_we, "R6 host strobe", {host_we, guest_we}, 2);
            chk(random_rd < 64 && random_rd == host_addr, "R6 random matches entry", random_rd, host_addr);
            step();
        end
    endtask

    task automatic t_priority();
        load_index(20);
        write_indexed = 1'b1;
        write_random  = 1'b1;
        entry_mask    = GMASK;
        step();
        write_indexed = 1'b0;
        write_random  = 1'b0;
        chk(host_we && !guest_we && host_addr == 20, "R8 indexed wins", host_addr, 20);
        step();
    endtask

    task automatic t_flush_host();
        int gv;
        gv = $countones(guest_valid);
        diag_wr    = 1'b1;
        diag_wdata = 2'b01;
        step();
        diag_wr    = 1'b0;
        diag_wdata = 2'b00;
        chk(host_flush && !guest_flush, "R9 host pulse", {host_flush, guest_flush}, 2);
        chk($countones(host_valid) == 0, "R9 host cleared", $countones(host_valid), 0);
        chk($countones(guest_valid) == gv && gv > 0, "R9 guest kept", $countones(guest_valid), gv);
        step();
        chk(!host_flush, "R9 host pulse one cycle", host_flush, 0);
    endtask

    task automatic t_flush_guest();
        idx_write(30, 1'b1, 30, 48'h30);
        diag_wr    = 1'b1;
        diag_wdata = 2'b10;
        step();
        diag_wr    = 1'b0;
        diag_wdata = 2'b00;
        chk(guest_flush && !host_flush, "R9 guest pulse", {host_flush, guest_flush}, 1);
        chk($countones(guest_valid) == 0, "R9 guest cleared", $countones(guest_valid), 0);
        chk(host_valid[30] && $countones(host_valid) == 1, "R9 host kept", $countones(host_valid), 1);
        step();
        chk(!guest_flush, "R9 guest pulse one cycle", guest_flush, 0);
    endtask

    task automatic t_flush_with_write();
        idx_write(11, 1'b1, 11, 48'h11);
        load_index(7);
        diag_wr       = 1'b1;
        diag_wdata    = 2'b01;
        write_indexed = 1'b1;
        step();
        diag_wr       = 1'b0;
        diag_wdata    = 2'b00;
        write_indexed = 1'b0;
        chk(host_valid[7] && $countones(host_valid) == 1, "R10 write survives flush",
            $countones(host_valid), 1);
        step();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_index_load();
        t_indexed();
        t_load_and_write_same_cycle();
        t_out_of_range();
        t_random_guest();
        t_random_host();
        t_priority();
        t_flush_host();
        t_flush_guest();
        t_flush_with_write();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule